// File: doc/BRIEF.md
# Off-Mode Wakeup Power Sequencer

This block runs a chip's climb out of its deepest power-down state. A wakeup request starts the sequence. The block first asks for the system clock. It then releases the off-mode indication so that the core supplies can begin to ramp, and brings up the two core rails. Finally it waits until the requested clock has had its programmed time to settle, and then reports completion.

The rails come up in one of two ways, chosen by a mode input. In internal mode the block issues a voltage command for each rail over a request/acknowledge pair that leads to a serial-bus master. The second rail goes first. After each acknowledge the block waits that rail's programmed setup time, counted as eight system clocks per unit. In external mode a separate power-management device sequences the rails itself. The block then waits one overall delay, counted in edges of the 32 kHz clock.

The delay from asking for the clock to releasing off-mode is also programmed in 32 kHz edges. The clock-settling timer runs in parallel from the moment of the request, so the rail ramps overlap the settling wait. All 32 kHz timing is done by synchronising the slow clock into the system domain and counting its rising edges. The setup inputs are captured when a sequence starts. The done flag holds until the wakeup request is withdrawn, and the block then returns to idle.

Top module: `offmode_wake_seq`

## Requirements
- R1: After reset and while idle, `off_mode` is 1, and `clk_req`, both command strobes and `done` are 0.
- R2: A wakeup request raises `clk_req` one cycle later. With a zero offset, `off_mode` falls two cycles after `clk_req` rises, and never before `clk_req` is high.
- R3: `off_mode` stays 1 after `clk_req` rises for `offset` rising edges of `slow_clk` (a tolerance of one edge is allowed for synchronisation), then falls.
- R4: In internal mode (`ext_mode`=0) the second-rail strobe `rail2_cmd` comes before the first-rail strobe `rail1_cmd`. The two strobes are never high together. Each strobe holds until a cycle in which `cmd_ack` is 1.
- R5: In internal mode the next step begins 8×count+1 cycles after the cycle that captured the acknowledge. The first-rail count is `rail_setup[15:0]` and the second-rail count is `rail_setup[31:16]`.
- R6: In external mode (`ext_mode`=1) no command strobe is issued, and the rail stage lasts `ext_setup` rising edges of `slow_clk` (±1).
- R7: `done` does not rise before `clk_setup` rising edges of `slow_clk` (less one for synchronisation) have passed since `clk_req` rose.
- R8: A count of zero ends its stage in one cycle. With every count at zero and an immediate acknowledge, `done` rises 7 cycles after `clk_req` in internal mode and 4 cycles after it in external mode.
- R9: The mode and all setup inputs are captured when the request is accepted. Later changes do not affect the running sequence.
- R10: `done` stays 1 while `wake_req` is held. One cycle after `wake_req` falls, the block is idle again with `clk_req`=0 and `off_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Free-running 32 kHz clock, asynchronous |
| wake_req | input | 1 | Wakeup request; level, held until done is seen |
| ext_mode | input | 1 | 0: rails sequenced internally, 1: external power IC |
| rail_setup | input | 32 | [15:0] first-rail count, [31:16] second-rail count (×8 system clocks) |
| clk_setup | input | 16 | Clock-settling wait in slow-clock edges |
| ext_setup | input | 16 | External-mode overall wait in slow-clock edges |
| offset | input | 16 | Clock request to off-mode release, in slow-clock edges |
| cmd_ack | input | 1 | Acknowledge of the current voltage command |
| clk_req | output | 1 | System clock request |
| off_mode | output | 1 | Off-mode indication to the supplies |
| rail1_cmd | output | 1 | First-rail voltage command strobe |
| rail2_cmd | output | 1 | Second-rail voltage command strobe |
| done | output | 1 | Wakeup sequence complete |

## Verification
The hardest case to bring about is the overlap. The clock-settling timer must still be running after both rail ramps have finished, so that only the slow clock decides when `done` rises. One vector sets a long settling count with short rail counts and a delayed acknowledge to force this. The synchroniser makes slow-edge timing uncertain by one edge, so those checks count `slow_clk` edges in the bench and allow that margin. The system-clock stages are instead checked to the exact cycle, counting from the negedge on which the bench drove the acknowledge.

// File: rtl/offmode_wake_seq.sv
module offmode_wake_seq #(
  parameter int CNT_W    = 16,
  parameter int SCALE_SH = 3,
  parameter int SYNC_N   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_clk,
  input  logic               wake_req,
  input  logic               ext_mode,
  input  logic [2*CNT_W-1:0] rail_setup,
  input  logic [CNT_W-1:0]   clk_setup,
  input  logic [CNT_W-1:0]   ext_setup,
  input  logic [CNT_W-1:0]   offset,
  input  logic               cmd_ack,
  output logic               clk_req,
  output logic               off_mode,
  output logic               rail1_cmd,
  output logic               rail2_cmd,
  output logic               done
);
  localparam int WAIT_W = CNT_W + SCALE_SH;

  typedef enum logic [3:0] {
    S_IDLE, S_CLKREQ, S_OFFSET, S_R2_CMD, S_R2_WAIT,
    S_R1_CMD, S_R1_WAIT, S_EXT_WAIT, S_CLK_WAIT, S_DONE
  } state_t;

  state_t            state;
  logic [SYNC_N:0]   slow_sync;
  logic              tick;
  logic [WAIT_W-1:0] wait_cnt;
  logic [CNT_W-1:0]  cs_cnt;
  logic              wait_zero;
  logic              mode_q;
  logic [CNT_W-1:0]  rail1_q, rail2_q, clk_q, ext_q, off_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slow_sync <= '0;
    else        slow_sync <= {slow_sync[SYNC_N-1:0], slow_clk};

  assign tick      = slow_sync[SYNC_N-1] & ~slow_sync[SYNC_N];
  assign wait_zero = (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wait_cnt <= '0;
      cs_cnt   <= '0;
      mode_q   <= 1'b0;
      rail1_q  <= '0;
      rail2_q  <= '0;
      clk_q    <= '0;
      ext_q    <= '0;
      off_q    <= '0;
    end else begin
      if (tick && cs_cnt != '0) cs_cnt <= cs_cnt - 1'b1;
      case (state)
        S_IDLE:
          if (wake_req) begin
            mode_q  <= ext_mode;
            rail1_q <= rail_setup[CNT_W-1:0];
            rail2_q <= rail_setup[2*CNT_W-1:CNT_W];
            clk_q   <= clk_setup;
            ext_q   <= ext_setup;
            off_q   <= offset;
            state   <= S_CLKREQ;
          end
        S_CLKREQ: begin
          wait_cnt <= WAIT_W'(off_q);
          cs_cnt   <= clk_q;
          state    <= S_OFFSET;
        end
        S_OFFSET:
          if (wait_zero) begin
            if (mode_q) begin
              wait_cnt <= WAIT_W'(ext_q);
              state    <= S_EXT_WAIT;
            end else begin
              state    <= S_R2_CMD;
            end
          end else if (tick) begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        S_R2_CMD:
          if (cmd_ack) begin
            wait_cnt <= {rail2_q, {SCALE_SH{1'b0}}};
            state    <= S_R2_WAIT;
          end
        S_R2_WAIT:
          if (wait_zero) state <= S_R1_CMD;
          else           wait_cnt <= wait_cnt - 1'b1;
        S_R1_CMD:
          if (cmd_ack) begin
            wait_cnt <= {rail1_q, {SCALE_SH{1'b0}}};
            state    <= S_R1_WAIT;
          end
        S_R1_WAIT:
          if (wait_zero) state <= S_CLK_WAIT;
          else           wait_cnt <= wait_cnt - 1'b1;
        S_EXT_WAIT:
          if (wait_zero)  state <= S_CLK_WAIT;
          else if (tick)  wait_cnt <= wait_cnt - 1'b1;
        S_CLK_WAIT:
          if (cs_cnt == '0) state <= S_DONE;
        S_DONE:
          if (!wake_req) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign clk_req   = (state != S_IDLE);
  assign off_mode  = (state == S_IDLE) || (state == S_CLKREQ) || (state == S_OFFSET);
  assign rail2_cmd = (state == S_R2_CMD);
  assign rail1_cmd = (state == S_R1_CMD);
  assign done      = (state == S_DONE);
endmodule

// File: rtl/offmode_wake_seq_chk.sv
module offmode_wake_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_req,
  input logic cmd_ack,
  input logic clk_req,
  input logic off_mode,
  input logic rail1_cmd,
  input logic rail2_cmd,
  input logic done,
  input logic mode_q
);
  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_req |-> off_mode && !done && !rail1_cmd && !rail2_cmd);

  a_r2_off_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_mode) |-> clk_req);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail1_cmd && rail2_cmd));

  a_r4_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rail2_cmd && !cmd_ack |=> rail2_cmd);

  a_r4_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rail1_cmd && !cmd_ack |=> rail1_cmd);

  a_r4_off_first: assert property (@(posedge clk) disable iff (!rst_n)
    off_mode |-> !rail1_cmd && !rail2_cmd && !done);

  a_r6_ext_silent: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && clk_req |-> !rail1_cmd && !rail2_cmd);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && wake_req |=> done);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wake_req |=> !clk_req && off_mode);
endmodule

bind offmode_wake_seq offmode_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .cmd_ack(cmd_ack),
  .clk_req(clk_req), .off_mode(off_mode), .rail1_cmd(rail1_cmd),
  .rail2_cmd(rail2_cmd), .done(done), .mode_q(mode_q)
);

// File: tb/offmode_wake_seq_bench.sv
`timescale 1ns/1ps
module offmode_wake_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic        wake_req = 1'b0, ext_mode = 1'b0, cmd_ack = 1'b0;
  logic [31:0] rail_setup = '0;
  logic [15:0] clk_setup = '0, ext_setup = '0, offset = '0;
  logic        clk_req, off_mode, rail1_cmd, rail2_cmd, done;

  offmode_wake_seq u_offmode_wake_seq (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wake_req(wake_req),
    .ext_mode(ext_mode), .rail_setup(rail_setup), .clk_setup(clk_setup),
    .ext_setup(ext_setup), .offset(offset), .cmd_ack(cmd_ack),
    .clk_req(clk_req), .off_mode(off_mode), .rail1_cmd(rail1_cmd),
    .rail2_cmd(rail2_cmd), .done(done)
  );

  always #5 clk = ~clk;
  always #100 slow_clk = ~slow_clk;

  int slow_edges = 0;
  always @(posedge slow_clk) slow_edges++;

  int nchk = 0, nfail = 0;

  // fields: mode, r1, r2, clk_setup, ext_setup, offset, ack_delay
  localparam int NV = 6;
  localparam logic [111:0] VEC [NV] = '{
    {16'd0, 16'd2,  16'd5, 16'd0,  16'd0, 16'd3, 16'd0},
    {16'd0, 16'd0,  16'd1, 16'd0,  16'd9, 16'd0, 16'd4},
    {16'd0, 16'd7,  16'd0, 16'd12, 16'd0, 16'd1, 16'd2},
    {16'd1, 16'd9,  16'd9, 16'd0,  16'd4, 16'd2, 16'd0},
    {16'd1, 16'd0,  16'd0, 16'd6,  16'd1, 16'd0, 16'd0},
    {16'd0, 16'd16, 16'd3, 16'd3,  16'd0, 16'd5, 16'd1}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int c_req, c_off, c_r2, c_r1, a2, a1, c_done, r2_hi, r1_hi;
  int e_req, e_off, e_done;
  int late_r2;

  task automatic run_seq(input bit m, input int r1, input int r2, input int cs,
                         input int ex, input int off, input int ackd, input bit poke);
    int cyc = 0, ackw = 0;
    c_req = -1; c_off = -1; c_r2 = -1; c_r1 = -1; a2 = -1; a1 = -1;
    c_done = -1; r2_hi = 0; r1_hi = 0;
    @(negedge clk);
    ext_mode = m; rail_setup = {r2[15:0], r1[15:0]};
    clk_setup = cs[15:0]; ext_setup = ex[15:0]; offset = off[15:0];
    wake_req = 1'b1;
    while (c_done < 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      cmd_ack = 1'b0;
      if (clk_req && c_req < 0) begin
        c_req = cyc; e_req = slow_edges;
        if (poke) begin
          rail_setup = {late_r2[15:0], 16'd30};
          ext_mode = ~m; offset = 16'd40; clk_setup = 16'd40;
        end
      end
      if (!off_mode && c_off < 0) begin c_off = cyc; e_off = slow_edges; end
      if (rail2_cmd) begin if (c_r2 < 0) c_r2 = cyc; r2_hi++; end
      if (rail1_cmd) begin if (c_r1 < 0) c_r1 = cyc; r1_hi++; end
      if (rail1_cmd || rail2_cmd) begin
        if (ackw == ackd) begin
          cmd_ack = 1'b1;
          if (rail2_cmd) a2 = cyc; else a1 = cyc;
          ackw = 0;
        end else ackw++;
      end
      if (done) begin c_done = cyc; e_done = slow_edges; end
    end
    check("R10 watchdog", c_done >= 0, cyc, 0);
  endtask

  task automatic finish_seq();
    repeat (3) begin
      @(negedge clk);
      check("R10 done held", done === 1'b1, done, 1);
    end
    wake_req = 1'b0;
    @(negedge clk);
    check("R10 idle clk_req", clk_req === 1'b0, clk_req, 0);
    check("R10 idle off_mode", off_mode === 1'b1, off_mode, 1);
    check("R10 idle done", done === 1'b0, done, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1500000;
    nfail++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
    $finish;
  end

  initial begin
    late_r2 = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 off_mode", off_mode === 1'b1, off_mode, 1);
    check("R1 clk_req", clk_req === 1'b0, clk_req, 0);
    check("R1 strobes", (rail1_cmd | rail2_cmd) === 1'b0, rail1_cmd | rail2_cmd, 0);
    check("R1 done", done === 1'b0, done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [111:0] v = VEC[i];
      automatic bit m  = v[96];
      automatic int r1 = int'(v[95:80]);
      automatic int r2 = int'(v[79:64]);
      automatic int cs = int'(v[63:48]);
      automatic int ex = int'(v[47:32]);
      automatic int of = int'(v[31:16]);
      automatic int ak = int'(v[15:0]);
      run_seq(m, r1, r2, cs, ex, of, ak, 1'b0);
      if (of == 0)
        check("R2 zero offset", c_off == c_req + 2, c_off - c_req, 2);
      check("R3 offset edges", (e_off - e_req) >= of - 1 && (e_off - e_req) <= of + 1,
            e_off - e_req, of);
      if (!m) begin
        check("R4 order", c_r2 > 0 && c_r1 > c_r2, c_r1, c_r2 + 1);
        check("R4 hold r2", r2_hi == ak + 1, r2_hi, ak + 1);
        check("R4 hold r1", r1_hi == ak + 1, r1_hi, ak + 1);
        check("R5 rail2 wait", c_r1 == a2 + 8 * r2 + 2, c_r1 - a2, 8 * r2 + 2);
        if (cs == 0)
          check("R5 rail1 wait", c_done == a1 + 8 * r1 + 3, c_done - a1, 8 * r1 + 3);
      end else begin
        check("R6 no strobes", r1_hi == 0 && r2_hi == 0, r1_hi + r2_hi, 0);
        if (cs == 0)
          check("R6 ext edges", (e_done - e_off) >= ex - 1 && (e_done - e_off) <= ex + 1,
                e_done - e_off, ex);
      end
      if (cs > 0)
        check("R7 clock settle", (e_done - e_req) >= cs - 1, e_done - e_req, cs);
      finish_seq();
    end

    // R8 all-zero internal
    run_seq(1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
    check("R8 zero internal", c_done == c_req + 7, c_done - c_req, 7);
    finish_seq();
    // R8 all-zero external
    run_seq(1'b1, 0, 0, 0, 0, 0, 0, 1'b0);
    check("R8 zero external", c_done == c_req + 4, c_done - c_req, 4);
    finish_seq();

    // R9 capture: inputs change after start
    late_r2 = 12;
    run_seq(1'b0, 1, 3, 0, 0, 0, 0, 1'b1);
    check("R9 mode kept", c_r2 > 0, c_r2, 1);
    check("R9 rail2 kept", c_r1 == a2 + 26, c_r1 - a2, 26);
    check("R9 rail1 kept", c_done == a1 + 11, c_done - a1, 11);
    check("R9 offset kept", c_off == c_req + 2, c_off - c_req, 2);
    finish_seq();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule